// File: doc/BRIEF.md
# Indexed Block Configuration Register Target

This block is a two-wire serial target that keeps a small bank of eight-bit configuration registers for a clock-distribution controller. A host reaches the bank with two framed transactions. To write, it sends a starting index, then a byte count, then that many data bytes. To read, it sends a starting index, then a repeated start with the read address. The target replies with a byte count and then the register contents from that index onward. Three of the registers drive parallel outputs: a drive-mode byte, a per-output enable mask and a per-output stoppable mask.

Both bus lines are sampled in the system clock domain through two-flop synchronizers. Start and stop conditions are recognised on the synchronized lines. SDA is open-drain and is modelled as a pull-low enable. A writable count register decides how many data bytes a read returns. After that many bytes the target lets the line float high. One register returns identity values that cannot be changed, and the reserved locations always read as zero.

Top module: `idxblk_target`

## Requirements
- R1: After reset the bank holds: index 0 = 0x07, index 1 = 0xFF, index 2 = 0x00, index 5 = 0x83, index 6 = 0x07. The outputs mode_o, oe_o and stop_o show indices 0, 1 and 2.
- R2: The 8-bit address byte 0xDC (write) is acknowledged, and so is 0xDD (read). Any other address byte is not acknowledged, and the rest of that frame is not acknowledged and changes no register.
- R3: A write frame is: address 0xDC, start index N, count X, data bytes. Data bytes 1 to X go to indices N, N+1, and so on, and the target acknowledges each of them.
- R4: In a write frame, data bytes past the count X are not acknowledged and are not stored.
- R5: A read frame is: address 0xDC, index N, repeated start, address 0xDD. The target then sends the value of index 6 first, followed by the registers from index N upward.
- R6: Once it has sent as many data bytes as index 6 holds, the target releases SDA, so any further byte reads as 0xFF.
- R7: A host NACK ends the read. The target drives nothing more until the next start, so extra clocked bytes read as 0xFF.
- R8: Index 4 reads {REV_ID, 4'b0001} (0x21 with defaults). Indices 3 and 7 read 0x00, and bits 5:3 of index 0 read 0. Writes to any of these are acknowledged but change nothing; bits 7, 6 and 2:0 of index 0 and all bits of indices 1, 2, 5 and 6 are writable.
- R9: The index advances after every data byte and wraps from 7 to 0, for both writes and reads.
- R10: A start in mid-frame abandons the frame and begins a new address phase. A stop returns the target to idle.
- R11: The target changes its SDA drive only while SCL is low.
- R12: The register outputs change only as the result of an acknowledged write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| mode_o | output | 8 | Drive-mode register (index 0) |
| oe_o | output | 8 | Output enable mask (index 1) |
| stop_o | output | 8 | Stoppable mask (index 2) |

## Verification
The hardest state to reach is a start condition that lands in the middle of a byte, after an address that was acknowledged. The bench gets there by sending the write address and then only three bits of the index. It then raises SDA while SCL is low and issues a start, and follows with a complete write. Only the later write may take effect. The second hard case is a read that runs past the count register. The bench first rewrites the count to a small value and then clocks more bytes than that, so the released-line 0xFF bytes can be told apart from the data bytes.

// File: rtl/idxblk_pkg.sv
package idxblk_pkg;
  localparam int REG_COUNT = 8;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int IDX_MODE  = 0;
  localparam int IDX_OE    = 1;
  localparam int IDX_STOP  = 2;
  localparam int IDX_ID    = 4;
  localparam int IDX_CNT   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_IDX, ST_CNT, ST_WDAT, ST_RTX
  } fsm_e;

  // Bits that a host write may change, per register index.
  function automatic logic [7:0] wmask(int i);
    case (i)
      0:          return 8'hC7;
      1, 2, 5, 6: return 8'hFF;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rstval(int i);
    case (i)
      0:       return 8'h07;
      1:       return 8'hFF;
      5:       return 8'h83;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/idxblk_sync.sv
module idxblk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_q,
  output logic sda_q
);
  localparam int LINES = 2;

  logic [STAGES-1:0] rs_q;
  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) rs_q <= '0;
    else          rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end
  assign rst_n = rs_q[STAGES-1];

  logic [LINES-1:0] raw, syn, dly;
  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        dly[l] <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], raw[l]};
        dly[l] <= chain[STAGES-1];
      end
    end
    assign syn[l] = chain[STAGES-1];
  end

  assign scl_s = syn[0];
  assign sda_s = syn[1];
  assign scl_q = dly[0];
  assign sda_q = dly[1];
endmodule

// File: rtl/idxblk_regfile.sv
module idxblk_regfile
  import idxblk_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [7:0]       mode_o,
  output logic [7:0]       oe_o,
  output logic [7:0]       stop_o,
  output logic [7:0]       count_o
);
  logic [REG_COUNT-1:0][7:0] q;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [7:0] MSK = wmask(g);
    localparam logic [7:0] RST = rstval(g);
    localparam logic [7:0] FIX = (g == IDX_ID) ? {REV_ID, 4'h1} : 8'h00;
    if (MSK != 8'h00) begin : g_ff
      logic       en;
      logic [7:0] q_r;
      assign en = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= RST & MSK;
        else if (en) q_r <= wr_data & MSK;
      end
      assign q[g] = q_r | (FIX & ~MSK);
    end else begin : g_fix
      assign q[g] = FIX;
    end
  end

  assign rd_data = q[rd_idx];
  assign mode_o  = q[IDX_MODE];
  assign oe_o    = q[IDX_OE];
  assign stop_o  = q[IDX_STOP];
  assign count_o = q[IDX_CNT];
endmodule

// File: rtl/idxblk_target.sv
module idxblk_target
  import idxblk_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'hDC,
  parameter logic [7:0] RD_ADDR     = WR_ADDR | 8'h01,
  parameter logic [3:0] REV_ID      = 4'h2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] mode_o,
  output logic [7:0] oe_o,
  output logic [7:0] stop_o
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] ACK_END  = 4'd9;

  logic rst_s, scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  idxblk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n_a(rst_n), .rst_n(rst_s),
    .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_q(scl_q), .sda_q(sda_q)
  );

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  fsm_e             st, st_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       sh, sh_n, tx, tx_n, left, left_n, nxt;
  logic [IDX_W-1:0] idx, idx_n;
  logic             oe_n, ack_ok, wr_en;
  logic [7:0]       rd_data, count;

  idxblk_regfile #(.REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .wr_en(wr_en), .wr_idx(idx), .wr_data(sh),
    .rd_idx(idx), .rd_data(rd_data),
    .mode_o(mode_o), .oe_o(oe_o), .stop_o(stop_o), .count_o(count)
  );

  always_comb begin
    case (st)
      ST_ADDR:        ack_ok = (sh == WR_ADDR) || (sh == RD_ADDR);
      ST_IDX, ST_CNT: ack_ok = 1'b1;
      ST_WDAT:        ack_ok = (left != 8'd0);
      default:        ack_ok = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; tx_n = tx;
    left_n = left; idx_n = idx; oe_n = sda_oe; wr_en = 1'b0;
    nxt = (left != 8'd0) ? rd_data : 8'hFF;
    if (stop_det) begin
      st_n = ST_IDLE; cnt_n = '0; oe_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else if (st == ST_RTX) begin
      if (scl_rise) begin
        if (cnt < ACK_SLOT)       cnt_n = cnt + 4'd1;
        else if (cnt == ACK_SLOT) begin
          if (sda_s) st_n = ST_IDLE;   // host NACK ends the read
          else       cnt_n = ACK_END;
        end
      end else if (scl_fall) begin
        if (cnt >= 4'd1 && cnt < ACK_SLOT) begin
          tx_n = {tx[6:0], 1'b1};
          oe_n = ~tx[6];
        end else if (cnt == ACK_SLOT) begin
          oe_n = 1'b0;
        end else if (cnt == ACK_END) begin
          tx_n  = nxt;
          oe_n  = ~nxt[7];
          cnt_n = '0;
          if (left != 8'd0) begin
            idx_n  = idx + IDX_W'(1);
            left_n = left - 8'd1;
          end
        end
      end
    end else if (st != ST_IDLE) begin
      if (scl_rise && cnt < ACK_SLOT) begin
        sh_n  = {sh[6:0], sda_s};
        cnt_n = cnt + 4'd1;
      end else if (scl_fall && cnt == ACK_SLOT) begin
        cnt_n = ACK_END;
        oe_n  = ack_ok;
        if (st == ST_WDAT && ack_ok) begin
          wr_en  = 1'b1;
          idx_n  = idx + IDX_W'(1);
          left_n = left - 8'd1;
        end
      end else if (scl_fall && cnt == ACK_END) begin
        cnt_n = '0;
        oe_n  = 1'b0;
        case (st)
          ST_ADDR: begin
            if (sh == WR_ADDR) st_n = ST_IDX;
            else if (sh == RD_ADDR) begin
              st_n   = ST_RTX;
              tx_n   = count;
              left_n = count;
              oe_n   = ~count[7];
            end else st_n = ST_IDLE;
          end
          ST_IDX: begin
            idx_n = sh[IDX_W-1:0];
            st_n  = ST_CNT;
          end
          ST_CNT: begin
            left_n = sh;
            st_n   = ST_WDAT;
          end
          default: ;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '1;
      left <= '0; idx <= '0; sda_oe <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; tx <= tx_n;
      left <= left_n; idx <= idx_n; sda_oe <= oe_n;
    end
  end
endmodule

// File: rtl/idxblk_checker.sv
module idxblk_checker
  import idxblk_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hDC,
  parameter logic [7:0] RD_ADDR = 8'hDD
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input fsm_e       st,
  input logic [3:0] cnt,
  input logic [7:0] sh,
  input logic       wr_en,
  input logic       start_det,
  input logic       stop_det,
  input logic [7:0] mode_o,
  input logic [7:0] oe_o,
  input logic [7:0] stop_o
);
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_foreign_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && cnt == 4'd9 && sh != WR_ADDR && sh != RD_ADDR) |-> !sda_oe);

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mode_o, oe_o, stop_o}) |-> $past(wr_en));

  assert_write_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> st == ST_WDAT);

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == ST_IDLE);

  assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && cnt == 4'd0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_oe);
endmodule

bind idxblk_target idxblk_checker #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .st(st), .cnt(cnt), .sh(sh), .wr_en(wr_en),
  .start_det(start_det), .stop_det(stop_det),
  .mode_o(mode_o), .oe_o(oe_o), .stop_o(stop_o)
);

// File: tb/idxblk_target_bench.sv
module idxblk_target_bench;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1;
  logic sda_bus, sda_oe;
  logic [7:0] mode_o, oe_o, stop_o;
  assign sda_bus = hsda & ~sda_oe;
  always #5 clk = ~clk;

  idxblk_target u_idxblk_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .mode_o(mode_o), .oe_o(oe_o), .stop_o(stop_o)
  );

  int checks = 0, errors = 0, hi_changes = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], act_q[$], wdata_q[$];
  string tag_q[$];
  logic prev_oe = 1'b0;

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  // SDA drive must only move while SCL is low (R11)
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) hi_changes++;
    prev_oe = sda_oe;
  end

  // Scoreboard monitor: compares captured bytes with queued expectations
  initial forever begin
    @(posedge clk); #1;
    while (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", a, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  task automatic expect_b(logic [7:0] b, string tag);
    exp_q.push_back(b); tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    hsda = 1'b1; wq(Q); scl = 1'b1; wq(Q); hsda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    hsda = 1'b0; wq(Q); scl = 1'b1; wq(Q); hsda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(logic b);
    hsda = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    hsda = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic wbyte(logic [7:0] d, logic exp_ack, string tag);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    chk(!b == exp_ack, tag, {7'd0, !b}, {7'd0, exp_ack});
  endtask

  task automatic rbyte(logic host_ack);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!host_ack);
    act_q.push_back(d);
  endtask

  task automatic blk_write(logic [7:0] idx, logic [7:0] cnt, string tag);
    int n;
    n = wdata_q.size();
    bus_start();
    wbyte(8'hDC, 1'b1, {tag, " addr ack"});
    wbyte(idx, 1'b1, {tag, " index ack"});
    wbyte(cnt, 1'b1, {tag, " count ack"});
    for (int i = 0; i < n; i++) wbyte(wdata_q.pop_front(), (i < cnt), {tag, " data ack"});
    bus_stop();
    wq(4);
  endtask

  task automatic blk_read(logic [7:0] idx, int n, int extra, string tag);
    bus_start();
    wbyte(8'hDC, 1'b1, {tag, " waddr ack"});
    wbyte(idx, 1'b1, {tag, " index ack"});
    bus_start();
    wbyte(8'hDD, 1'b1, {tag, " raddr ack"});
    rbyte(1'b1);
    for (int i = 0; i < n; i++) rbyte(i != n - 1);
    for (int i = 0; i < extra; i++) rbyte(1'b0);
    bus_stop();
    wq(4);
  endtask

  task automatic outs(logic [7:0] m, logic [7:0] o, logic [7:0] s, string tag);
    chk(mode_o == m, {tag, " mode_o"}, mode_o, m);
    chk(oe_o == o, {tag, " oe_o"}, oe_o, o);
    chk(stop_o == s, {tag, " stop_o"}, stop_o, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wq(5); rst_n = 1'b1; wq(10);
    outs(8'h07, 8'hFF, 8'h00, "R1 reset");

    // R1 R5 R8: full read from index 0 with the default count
    expect_b(8'h07, "R5 count byte");
    expect_b(8'h07, "R1 idx0"); expect_b(8'hFF, "R1 idx1"); expect_b(8'h00, "R1 idx2");
    expect_b(8'h00, "R8 idx3"); expect_b(8'h21, "R8 idx4"); expect_b(8'h83, "R1 idx5");
    expect_b(8'h07, "R1 idx6");
    blk_read(8'd0, 7, 0, "R5 read");

    // R3 block write
    wdata_q = '{8'hA5, 8'h3C};
    blk_write(8'd1, 8'd2, "R3 write");
    outs(8'h07, 8'hA5, 8'h3C, "R3 after write");

    // R8 masked bits in index 0
    wdata_q = '{8'hFF};
    blk_write(8'd0, 8'd1, "R8 write mode");
    outs(8'hC7, 8'hA5, 8'h3C, "R8 mode mask");

    // R8 reserved and read-only writes, then R7 early NACK + extra byte
    wdata_q = '{8'h55, 8'hAA, 8'h12};
    blk_write(8'd3, 8'd3, "R8 write ro");
    expect_b(8'h07, "R5 count byte");
    expect_b(8'h00, "R8 idx3 unchanged"); expect_b(8'h21, "R8 idx4 unchanged");
    expect_b(8'h12, "R3 idx5 written");  expect_b(8'hFF, "R7 after NACK");
    blk_read(8'd3, 3, 1, "R7 read");

    // R6 count register limits the read
    wdata_q = '{8'h02};
    blk_write(8'd6, 8'd1, "R6 write count");
    expect_b(8'h02, "R6 count byte");
    expect_b(8'hA5, "R6 data1"); expect_b(8'h3C, "R6 data2");
    expect_b(8'hFF, "R6 released1"); expect_b(8'hFF, "R6 released2");
    blk_read(8'd1, 4, 0, "R6 read");

    // R4 bytes beyond the count
    wdata_q = '{8'h11, 8'h22};
    blk_write(8'd1, 8'd1, "R4 write");
    outs(8'hC7, 8'h11, 8'h3C, "R4 overflow ignored");

    // R9 index wrap on write and read
    wdata_q = '{8'h99, 8'h5A};
    blk_write(8'd7, 8'd2, "R9 write");
    outs(8'h42, 8'h11, 8'h3C, "R9 wrap write");
    expect_b(8'h02, "R9 count byte");
    expect_b(8'h00, "R9 idx7"); expect_b(8'h42, "R9 idx0 wrapped");
    blk_read(8'd7, 2, 0, "R9 read");

    // R2 foreign addresses
    bus_start();
    wbyte(8'hA0, 1'b0, "R2 foreign addr");
    wbyte(8'h01, 1'b0, "R2 ignored index");
    wbyte(8'hFF, 1'b0, "R2 ignored data");
    bus_stop();
    bus_start();
    wbyte(8'hDE, 1'b0, "R2 near addr");
    bus_stop();
    wq(4);
    outs(8'h42, 8'h11, 8'h3C, "R2 R12 unchanged");

    // R10 start mid-byte, then stop mid-frame
    bus_start();
    wbyte(8'hDC, 1'b1, "R10 addr ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    wbyte(8'hDC, 1'b1, "R10 restart addr");
    wbyte(8'h02, 1'b1, "R10 index");
    wbyte(8'h01, 1'b1, "R10 count");
    wbyte(8'h0F, 1'b1, "R10 data");
    bus_stop();
    wq(4);
    outs(8'h42, 8'h11, 8'h0F, "R10 after abort");
    bus_start();
    wbyte(8'hDC, 1'b1, "R10 addr2");
    wbyte(8'h02, 1'b1, "R10 index2");
    bus_stop();
    wq(4);
    outs(8'h42, 8'h11, 8'h0F, "R10 stop mid-frame");
    expect_b(8'h02, "R10 count byte"); expect_b(8'h0F, "R10 idx2");
    blk_read(8'd2, 1, 0, "R10 read");

    wq(20);
    chk(exp_q.size() == 0, "scoreboard leftover", 8'(exp_q.size()), 8'h00);
    chk(hi_changes == 0, "R11 SDA moved with SCL high", 8'(hi_changes), 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule